// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Register

This block keeps a live copy of external line-detector inputs, two bits for each of four channels, and raises an active-low interrupt whenever an unmasked bit of that copy changes level in either direction. A second interrupt source is a new-transmit-data pulse, which only counts while an arm bit is set. Each source stays pending until the host strobes the read of its own register, or until a software or hardware reset.

Detector inputs pass a two-flop synchronizer. The copy register then compares each synchronized value against the value it holds and loads the new value. One selected detector bit can be filtered first. Its new level is accepted only after it has held for a programmable number of sample ticks. The interrupt pin can be driven push-pull, or run as an open-drain output that only pulls low.

Top module: `rtirq_top`

## Requirements
- R1: After rst_ni is released, rtd_o is all zeros, irq_n_o is 1, irq_oe_o is 1 with out_mode_i=0, and every mask bit is set.
- R2: A level applied to det_i[i] (i not equal to 0, or any i when deb_len_i=0) appears on rtd_o[i] after the third rising clock edge.
- R3: A change in either direction of an unmasked bit of rtd_o drives irq_n_o low in the same cycle that rtd_o shows the new value.
- R4: Mask bit i (mask_wd_i[i], written by mask_we_i and taking effect from the next edge) set to 1 stops a change of rtd_o[i] from raising the interrupt. rtd_o[i] still updates.
- R5: A txd_new_i pulse with txd_arm_i=1 drives irq_n_o low from the next cycle. With txd_arm_i=0 the pulse is ignored.
- R6: A pending source stays pending until its own read strobe: rd_rtd_i clears the change source and rd_txd_i clears the transmit source. irq_n_o stays low while either source is pending.
- R7: An unmasked change that arrives in the same cycle as rd_rtd_i keeps the change source pending.
- R8: sw_rst_i clears both pending sources at the next edge and overrides any event in that cycle. rtd_o is not altered.
- R9: With out_mode_i=0, irq_oe_o is always 1. With out_mode_i=1, irq_oe_o equals the pending state, and irq_n_o is 0 whenever irq_oe_o is 1.
- R10: For det_i[0] with deb_len_i=N>0, a new level reaches rtd_o[0] only after N deb_tick_i pulses during which the synchronized input differs from the accepted level. With N=0 the filter is bypassed.
- R11: If det_i[0] returns to its accepted level before N ticks have counted, the count is discarded and no change or interrupt results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| det_i | input | 8 | Raw detector inputs, bit 2*ch+k |
| deb_tick_i | input | 1 | Debounce sample tick |
| deb_len_i | input | 4 | Debounce length in ticks, 0 = bypass |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wd_i | input | 8 | Mask write data, 1 = masked |
| txd_arm_i | input | 1 | Arms the transmit-data source |
| txd_new_i | input | 1 | New transmit data pulse |
| rd_rtd_i | input | 1 | Read strobe of the detector register |
| rd_txd_i | input | 1 | Read strobe of the transmit data |
| sw_rst_i | input | 1 | Software clear of pending state |
| out_mode_i | input | 1 | 0 = push-pull, 1 = open-drain |
| rtd_o | output | 8 | Current detector register |
| irq_n_o | output | 1 | Interrupt level, active low |
| irq_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
Random detector words are applied under random masks. Because every vector is compared with the previous one, rising and falling flips, flips that are masked only and words that do not change at all are each told apart from a real interrupt. Directed sequences cover a read that lands in the change cycle, the arming of the transmit source and its two clear paths, and the two output modes. For the filtered bit, a tick count one short of the length is compared with the full length, and an input that reverts before the count completes is checked to leave no residue in the count.

// File: rtl/rtirq_pkg.sv
package rtirq_pkg;
  typedef enum logic {OUT_PUSH = 1'b0, OUT_OPEN = 1'b1} out_mode_e;
endpackage

// File: rtl/rtirq_sync.sv
module rtirq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rtirq_debounce.sv
module rtirq_debounce #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          d_i,
  input  logic          tick_i,
  input  logic [CW-1:0] len_i,
  output logic          q_o
);
  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic          bypass;

  assign bypass  = (len_i == '0);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (bypass) begin
      state_q <= d_i;
      cnt_q   <= '0;
    end else if (d_i == state_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_inc >= {1'b0, len_i}) begin
        state_q <= d_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_inc[CW-1:0];
      end
    end
  end

  assign q_o = bypass ? d_i : state_q;

  // R10
  deb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(len_i) != '0) && !$past(tick_i)) |-> $stable(state_q));
endmodule

// File: rtl/rtirq_core.sv
module rtirq_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  input  logic         arm_i,
  input  logic         txd_new_i,
  input  logic         rd_rtd_i,
  input  logic         rd_txd_i,
  input  logic         sw_rst_i,
  output logic [W-1:0] rtd_o,
  output logic         pend_o
);
  logic [W-1:0] rtd_q, mask_q, hit;
  logic         chg_pend_q, txd_pend_q;

  assign hit = (val_i ^ rtd_q) & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtd_q      <= '0;
      mask_q     <= '1;
      chg_pend_q <= 1'b0;
      txd_pend_q <= 1'b0;
    end else begin
      rtd_q <= val_i;
      if (mask_we_i) mask_q <= mask_wd_i;
      if (sw_rst_i) begin
        chg_pend_q <= 1'b0;
        txd_pend_q <= 1'b0;
      end else begin
        // new change wins over a simultaneous read
        chg_pend_q <= (chg_pend_q & ~rd_rtd_i) | (|hit);
        txd_pend_q <= (txd_pend_q & ~rd_txd_i) | (txd_new_i & arm_i);
      end
    end
  end

  assign rtd_o  = rtd_q;
  assign pend_o = chg_pend_q | txd_pend_q;

  // R3
  chg_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((((rtd_q ^ $past(rtd_q)) & ~$past(mask_q)) != '0) && !$past(sw_rst_i)) |-> chg_pend_q);
  // R6
  chg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_pend_q && !rd_rtd_i && !sw_rst_i) |=> chg_pend_q);
  // R6
  txd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_pend_q && !rd_txd_i && !sw_rst_i) |=> txd_pend_q);
  // R5
  txd_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txd_pend_q && !arm_i) |=> !txd_pend_q);
  // R8
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !pend_o);
endmodule

// File: rtl/rtirq_top.sv
module rtirq_top
  import rtirq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int BITS_PER_CH = 2,
  parameter int DEB_BIT     = 0,
  parameter int DEB_CW      = 4,
  localparam int NDET       = NUM_CH * BITS_PER_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NDET-1:0]   det_i,
  input  logic              deb_tick_i,
  input  logic [DEB_CW-1:0] deb_len_i,
  input  logic              mask_we_i,
  input  logic [NDET-1:0]   mask_wd_i,
  input  logic              txd_arm_i,
  input  logic              txd_new_i,
  input  logic              rd_rtd_i,
  input  logic              rd_txd_i,
  input  logic              sw_rst_i,
  input  logic              out_mode_i,
  output logic [NDET-1:0]   rtd_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic [NDET-1:0] det_s, det_f;
  logic            pend;

  rtirq_sync #(.W(NDET)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(det_i), .q_o(det_s)
  );

  for (genvar gi = 0; gi < NDET; gi++) begin : g_bit
    if (gi == DEB_BIT) begin : g_deb
      rtirq_debounce #(.CW(DEB_CW)) u_deb (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(det_s[gi]),
        .tick_i(deb_tick_i), .len_i(deb_len_i), .q_o(det_f[gi])
      );
    end else begin : g_raw
      assign det_f[gi] = det_s[gi];
    end
  end

  rtirq_core #(.W(NDET)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .val_i(det_f),
    .mask_we_i(mask_we_i), .mask_wd_i(mask_wd_i),
    .arm_i(txd_arm_i), .txd_new_i(txd_new_i),
    .rd_rtd_i(rd_rtd_i), .rd_txd_i(rd_txd_i), .sw_rst_i(sw_rst_i),
    .rtd_o(rtd_o), .pend_o(pend)
  );

  assign irq_n_o  = ~pend;
  assign irq_oe_o = (out_mode_e'(out_mode_i) == OUT_OPEN) ? pend : 1'b1;

  // R9
  od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_i && irq_n_o) |-> !irq_oe_o);
endmodule

// File: tb/rtirq_top_tb.sv
module rtirq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] det = '0;
  logic       tick = 1'b0;
  logic [3:0] dlen = '0;
  logic       mwe = 1'b0;
  logic [7:0] mwd = '0;
  logic       arm = 1'b0, txn = 1'b0, rdr = 1'b0, rdt = 1'b0, swr = 1'b0, omode = 1'b0;
  logic [7:0] rtd;
  logic       irq_n, irq_oe;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rtirq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .det_i(det), .deb_tick_i(tick), .deb_len_i(dlen),
    .mask_we_i(mwe), .mask_wd_i(mwd), .txd_arm_i(arm), .txd_new_i(txn),
    .rd_rtd_i(rdr), .rd_txd_i(rdt), .sw_rst_i(swr), .out_mode_i(omode),
    .rtd_o(rtd), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mask(logic [7:0] m);
    mwe = 1'b1; mwd = m; step(1); mwe = 1'b0;
  endtask

  task automatic read_all();
    rdr = 1'b1; rdt = 1'b1; step(1); rdr = 1'b0; rdt = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(1); tick = 1'b0;
  endtask

  function automatic logic exp_irq_n(logic [7:0] o, logic [7:0] n, logic [7:0] m);
    return ~(|((o ^ n) & ~m));
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] old_v, new_v, m;
    void'($urandom(32'd20250));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    check("R1 rtd", rtd, 8'h00);
    check("R1 irq_n", irq_n, 1'b1);
    check("R1 oe", irq_oe, 1'b1);
    // R1 R4: mask resets to all ones
    det = 8'hA5; step(3);
    check("R2 latency", rtd, 8'hA5);
    check("R1 mask reset", irq_n, 1'b1);

    // R2 latency edge: not yet after two edges
    det = 8'h5A; step(2);
    check("R2 early", rtd, 8'hA5);
    step(1);
    check("R2 arrive", rtd, 8'h5A);

    // random: R2 R3 R4
    old_v = 8'h5A;
    for (int i = 0; i < 60; i++) begin
      m = 8'($urandom());
      if (i % 5 == 0) m = 8'h00;
      set_mask(m);
      read_all();
      new_v = (i % 7 == 3) ? old_v : 8'($urandom());
      det = new_v;
      step(4);
      check("R2 rand rtd", rtd, new_v);
      check("R3 R4 rand irq", irq_n, exp_irq_n(old_v, new_v, m));
      old_v = new_v;
    end

    // R6 hold and rd_rtd clears
    set_mask(8'h00); read_all();
    det = old_v ^ 8'h80; old_v = det; step(4);
    check("R3 fall/rise", irq_n, 1'b0);
    step(10);
    check("R6 held", irq_n, 1'b0);
    rdt = 1'b1; step(1); rdt = 1'b0;
    check("R6 wrong strobe", irq_n, 1'b0);
    rdr = 1'b1; step(1); rdr = 1'b0;
    check("R6 cleared", irq_n, 1'b1);

    // R7 change coincident with read
    det = old_v ^ 8'h04; old_v = det; step(4);
    det = old_v ^ 8'h02; old_v = det; step(2);
    rdr = 1'b1; step(1); rdr = 1'b0;
    check("R7 kept", irq_n, 1'b0);
    check("R7 rtd", rtd, old_v);
    read_all();
    check("R7 then clear", irq_n, 1'b1);

    // R5 arm
    arm = 1'b0; txn = 1'b1; step(1); txn = 1'b0; step(1);
    check("R5 disarmed", irq_n, 1'b1);
    arm = 1'b1; txn = 1'b1; step(1); txn = 1'b0;
    check("R5 armed", irq_n, 1'b0);
    rdr = 1'b1; step(1); rdr = 1'b0;
    check("R6 txd keeps", irq_n, 1'b0);
    rdt = 1'b1; step(1); rdt = 1'b0;
    check("R6 txd clear", irq_n, 1'b1);

    // R9 output modes
    omode = 1'b1; step(1);
    check("R9 od idle oe", irq_oe, 1'b0);
    txn = 1'b1; step(1); txn = 1'b0;
    check("R9 od active oe", irq_oe, 1'b1);
    check("R9 od active lvl", irq_n, 1'b0);
    omode = 1'b0; step(1);
    check("R9 push oe", irq_oe, 1'b1);

    // R8 software clear overrides events
    det = old_v ^ 8'h10; old_v = det; step(2);
    swr = 1'b1; txn = 1'b1; step(1); swr = 1'b0; txn = 1'b0;
    check("R8 cleared", irq_n, 1'b1);
    check("R8 rtd kept", rtd, old_v);
    arm = 1'b0;

    // R10 debounce on bit 0
    det[0] = 1'b0; step(4); read_all();
    old_v = det;
    dlen = 4'd3; step(1);
    det[0] = 1'b1; step(3);
    check("R10 no tick", rtd[0], 1'b0);
    pulse_tick(); pulse_tick(); step(2);
    check("R10 short", rtd[0], 1'b0);
    check("R10 short irq", irq_n, 1'b1);
    pulse_tick(); step(1);
    check("R10 accepted", rtd[0], 1'b1);
    check("R10 irq", irq_n, 1'b0);
    read_all();

    // R11 glitch discarded
    det[0] = 1'b0; step(3);
    pulse_tick(); pulse_tick();
    det[0] = 1'b1; step(3);
    pulse_tick(); pulse_tick(); step(2);
    check("R11 no change", rtd[0], 1'b1);
    check("R11 no irq", irq_n, 1'b1);
    det[0] = 1'b0; step(3);
    pulse_tick(); pulse_tick(); step(2);
    check("R11 count restarted", rtd[0], 1'b1);
    pulse_tick(); step(1);
    check("R11 accepted", rtd[0], 1'b0);

    // R10 bypass
    dlen = 4'd0; read_all();
    det[0] = 1'b1; step(3);
    check("R10 bypass", rtd[0], 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule